// File: doc/BRIEF.md
# Bridge Uncorrectable Error Reporter

This block gathers uncorrectable data and address error events seen by a bridge between a PCIe link and a conventional PCI bus. It turns them into sticky status bits, an active-low parity error strobe on the conventional bus, and single-cycle requests for fatal or non-fatal error messages toward PCIe. Each event arrives as a one-cycle pulse on its own line of `evt_i`. The line says where the transaction started and what kind of transaction it was. Each status bit has its own rule for which events set it and which enable gates it. Posted and non-posted writes are reported differently.

Software reads the ten status bits directly from `stat_o`. It clears them through a write-one-to-clear port. The response to an event shows on the outputs one clock after the pulse is sampled.

Event lines on `evt_i`:

| Bit | Event |
|---|---|
| 0 | A PCIe-originated request got an immediate completion with a data error on the PCI side |
| 1 | Parity error sampled while forwarding a non-posted write from PCIe |
| 2 | Parity error sampled while forwarding a posted write from PCIe |
| 3 | System error sampled while forwarding from PCIe |
| 4 | A PCI-originated non-posted write carried a data error |
| 5 | A PCI-originated posted write carried a data error |

Status bits on `stat_o`:

| Bit | Meaning |
|---|---|
| 0 | Primary parity error detected |
| 1 | Device fatal error detected |
| 2 | Device non-fatal error detected |
| 3 | System error signalled |
| 4 | Secondary parity error detected |
| 5 | Master data parity error |
| 6 | Secondary system error received |
| 7 | Uncorrectable data error |
| 8 | Parity error asserted |
| 9 | System error asserted |

Top module: `bridge_uerr_report`

## Requirements
- R1: An event on `evt_i[0]` sets status bits 0 and 7 and one device bit. If parity response is enabled, it also sets bit 5 and produces one `perr_n_o` low cycle.
- R2: An event on `evt_i[1]` sets status bit 8 and one device bit. It sets bit 5 only when parity response is enabled. It never drives `perr_n_o` low.
- R3: An event on `evt_i[2]` sets status bit 8, and sets bit 5 when parity response is enabled. It leaves device bits 1 and 2 untouched and raises no message request.
- R4: An event on `evt_i[3]` sets status bits 6 and 9 and nothing else.
- R5: An event on `evt_i[4]` sets status bits 4 and 7 and one device bit. It does not touch bit 5 or `perr_n_o`.
- R6: An event on `evt_i[5]` sets status bits 4 and 7 and one device bit. If parity response is enabled, it also sets bit 5 and produces one `perr_n_o` low cycle.
- R7: While `perr_resp_en_i` is 0, status bit 5 is never set and no `perr_n_o` low cycle is queued.
- R8: The device bit chosen for a device-level event (bits 0, 1, 4, 5) depends on `sev_fatal_i` at the same index. A 1 selects bit 1 (fatal) and a 0 selects bit 2 (non-fatal).
- R9: `msg_req_o` pulses for one cycle, one cycle after a device-level event whose severity's reporting enable is set.
  - If a fatal event is enabled for reporting, `msg_fatal_o` is 1.
  - If fatal and non-fatal events coincide, a single fatal request is issued.
  - `msg_fatal_o` is 0 whenever `msg_req_o` is 0.
- R10: Status bit 3 is set in the same cycle that `msg_req_o` rises, and only if `serr_en_i` is 1.
- R11: Status bits are sticky.
  - A write with `clr_we_i` clears each bit whose `clr_data_i` bit is 1. A 0 leaves the bit unchanged.
  - When a set and a clear hit the same bit in the same cycle, the set wins.
  - Events in the same cycle are all recorded.
- R12: `perr_n_o` goes low for exactly one cycle per qualifying event. Two events in one cycle give two consecutive low cycles. Up to 7 pending strobes are kept, and further ones are dropped.
- R13: After reset, `stat_o` is 0, `perr_n_o` is 1 and `msg_req_o` and `msg_fatal_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6 | Error event pulses, one line per kind |
| perr_resp_en_i | input | 1 | Parity error response enable |
| serr_en_i | input | 1 | System error enable |
| fatal_rep_en_i | input | 1 | Enable for fatal message requests |
| nonfatal_rep_en_i | input | 1 | Enable for non-fatal message requests |
| sev_fatal_i | input | 6 | Per-event severity, 1 = fatal |
| clr_we_i | input | 1 | Status clear strobe |
| clr_data_i | input | 10 | Write-one-to-clear mask |
| stat_o | output | 10 | Sticky status bits |
| perr_n_o | output | 1 | Active-low parity error strobe |
| msg_req_o | output | 1 | Error message request pulse |
| msg_fatal_o | output | 1 | Message type, 1 = fatal |

## Verification
Directed cases drive each event line alone, with every enable set. This separates the six per-event setting rules, in particular the posted parity case that must leave the device bits alone. The same events are then repeated with parity response off, with all severities fatal, and with fatal reporting off. These runs tell gating faults apart from decode faults. Coincident events check the single fatal message and the two-cycle parity strobe. A clear in the same cycle as a set shows the set wins. Random sparse events, random enables and random clear masks, compared against a cycle model, then expose interaction faults and queue saturation.

// File: rtl/uerr_pkg.sv
package uerr_pkg;
   localparam int NUM_EVT = 6;
   localparam int STAT_W  = 10;

   localparam int EV_CPL     = 0;
   localparam int EV_PERR_NP = 1;
   localparam int EV_PERR_PW = 2;
   localparam int EV_SERR    = 3;
   localparam int EV_PCI_NP  = 4;
   localparam int EV_PCI_PW  = 5;

   localparam int ST_PDPE  = 0;
   localparam int ST_DFAT  = 1;
   localparam int ST_DNF   = 2;
   localparam int ST_SSE   = 3;
   localparam int ST_SDPE  = 4;
   localparam int ST_MDPE  = 5;
   localparam int ST_RSE   = 6;
   localparam int ST_UDATA = 7;
   localparam int ST_UPERR = 8;
   localparam int ST_USERR = 9;

   typedef logic [NUM_EVT-1:0] evt_t;
   typedef logic [STAT_W-1:0]  stat_t;

   // events that reach the device-level error bits
   localparam evt_t DEV_EVTS  = 6'b110011;
   // events that drive the parity strobe when enabled
   localparam evt_t STRB_EVTS = 6'b100001;
   // events that set master data parity when enabled
   localparam evt_t MDPE_EVTS = 6'b100111;

   localparam int CNT_W = $clog2(NUM_EVT + 1);
endpackage

// File: rtl/uerr_event_decode.sv
module uerr_event_decode
   import uerr_pkg::*;
(
   input  evt_t             evt,
   input  logic             perr_resp_en,
   input  evt_t             sev_fatal,
   output stat_t            set_vec,
   output logic             fat_hit,
   output logic             nf_hit,
   output logic [CNT_W-1:0] strb_cnt
);
   evt_t dev;

   always_comb begin
      dev      = evt & DEV_EVTS;
      fat_hit  = |(dev & sev_fatal);
      nf_hit   = |(dev & ~sev_fatal);
      set_vec  = '0;
      set_vec[ST_PDPE]  = evt[EV_CPL];
      set_vec[ST_SDPE]  = evt[EV_PCI_NP] | evt[EV_PCI_PW];
      set_vec[ST_UDATA] = evt[EV_CPL] | evt[EV_PCI_NP] | evt[EV_PCI_PW];
      set_vec[ST_UPERR] = evt[EV_PERR_NP] | evt[EV_PERR_PW];
      set_vec[ST_RSE]   = evt[EV_SERR];
      set_vec[ST_USERR] = evt[EV_SERR];
      set_vec[ST_MDPE]  = perr_resp_en & (|(evt & MDPE_EVTS));
      set_vec[ST_DFAT]  = fat_hit;
      set_vec[ST_DNF]   = nf_hit;
      strb_cnt = '0;
      for (int i = 0; i < NUM_EVT; i++) begin
         if (STRB_EVTS[i] && perr_resp_en) strb_cnt = strb_cnt + CNT_W'(evt[i]);
      end
   end
endmodule

// File: rtl/uerr_msg_gen.sv
module uerr_msg_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic fat_hit,
   input  logic nf_hit,
   input  logic fat_en,
   input  logic nf_en,
   output logic send_now,
   output logic msg_req,
   output logic msg_fatal
);
   logic send_fat;

   always_comb begin
      send_fat = fat_hit & fat_en;
      send_now = send_fat | (nf_hit & nf_en);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_req   <= 1'b0;
         msg_fatal <= 1'b0;
      end else begin
         msg_req   <= send_now;
         msg_fatal <= send_fat;
      end
   end

   // R9
   msg_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_fatal |-> msg_req);
   // R9
   msg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_req |-> $past(fat_hit | nf_hit));
endmodule

// File: rtl/uerr_perr_drv.sv
module uerr_perr_drv #(
   parameter int PEND_W = 3,
   parameter int CNT_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] new_cnt,
   output logic             perr_n
);
   localparam int TW = ((PEND_W > CNT_W) ? PEND_W : CNT_W) + 1;
   localparam logic [TW-1:0] MAXV = TW'((1 << PEND_W) - 1);

   logic [PEND_W-1:0] pend_q;
   logic [TW-1:0]     total, rem;
   logic              drive;

   always_comb begin
      total = TW'(pend_q) + TW'(new_cnt);
      drive = (total != '0);
      rem   = total - TW'(drive);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         perr_n <= 1'b1;
      end else begin
         pend_q <= (rem > MAXV) ? MAXV[PEND_W-1:0] : rem[PEND_W-1:0];
         perr_n <= ~drive;
      end
   end

   // R12
   strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q == '0 && new_cnt == '0) |=> perr_n);
   // R12
   strobe_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (new_cnt != '0) |=> !perr_n);
endmodule

// File: rtl/uerr_status_regs.sv
module uerr_status_regs #(
   parameter int W        = 10,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic         clr_we,
   input  logic [W-1:0] clr_data,
   output logic [W-1:0] stat
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic clr_i, nxt;
      assign clr_i = clr_we & clr_data[i];
      if (SET_WINS) begin : g_setw
         assign nxt = set_vec[i] | (stat[i] & ~clr_i);
         // R11
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> stat[i]);
      end else begin : g_clrw
         assign nxt = (set_vec[i] | stat[i]) & ~clr_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat[i] <= 1'b0;
         else        stat[i] <= nxt;
      end

      // R11
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (stat[i] && !clr_i) |=> stat[i]);
   end
endmodule

// File: rtl/bridge_uerr_report.sv
module bridge_uerr_report
   import uerr_pkg::*;
#(
   parameter int PEND_W   = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_EVT-1:0]  evt_i,
   input  logic                perr_resp_en_i,
   input  logic                serr_en_i,
   input  logic                fatal_rep_en_i,
   input  logic                nonfatal_rep_en_i,
   input  logic [NUM_EVT-1:0]  sev_fatal_i,
   input  logic                clr_we_i,
   input  logic [STAT_W-1:0]   clr_data_i,
   output logic [STAT_W-1:0]   stat_o,
   output logic                perr_n_o,
   output logic                msg_req_o,
   output logic                msg_fatal_o
);
   if (PEND_W < 2 || PEND_W > 8) begin : g_bad_pend
      $error("PEND_W must lie in 2..8");
   end

   stat_t            dec_set, all_set;
   logic             fat_hit, nf_hit, send_now;
   logic [CNT_W-1:0] strb_cnt;

   uerr_event_decode u_dec (
      .evt          (evt_i),
      .perr_resp_en (perr_resp_en_i),
      .sev_fatal    (sev_fatal_i),
      .set_vec      (dec_set),
      .fat_hit      (fat_hit),
      .nf_hit       (nf_hit),
      .strb_cnt     (strb_cnt)
   );

   uerr_msg_gen u_msg (
      .clk       (clk),
      .rst_n     (rst_n),
      .fat_hit   (fat_hit),
      .nf_hit    (nf_hit),
      .fat_en    (fatal_rep_en_i),
      .nf_en     (nonfatal_rep_en_i),
      .send_now  (send_now),
      .msg_req   (msg_req_o),
      .msg_fatal (msg_fatal_o)
   );

   always_comb begin
      all_set         = dec_set;
      all_set[ST_SSE] = send_now & serr_en_i;
   end

   uerr_status_regs #(.W(STAT_W), .SET_WINS(SET_WINS)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (all_set),
      .clr_we   (clr_we_i),
      .clr_data (clr_data_i),
      .stat     (stat_o)
   );

   uerr_perr_drv #(.PEND_W(PEND_W), .CNT_W(CNT_W)) u_perr (
      .clk     (clk),
      .rst_n   (rst_n),
      .new_cnt (strb_cnt),
      .perr_n  (perr_n_o)
   );

   // R3
   no_dev_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & DEV_EVTS) == '0) |=> !msg_req_o);
   // R7
   mdpe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!perr_resp_en_i && !stat_o[ST_MDPE]) |=> !stat_o[ST_MDPE]);
   // R10
   sse_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!serr_en_i && !stat_o[ST_SSE]) |=> !stat_o[ST_SSE]);
endmodule

// File: tb/bridge_uerr_report_tb.sv
module bridge_uerr_report_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] evt = '0, sev = '0;
   logic       pe = 1'b0, se = 1'b0, fe = 1'b0, ne = 1'b0, cw = 1'b0;
   logic [9:0] cd = '0;
   logic [9:0] stat;
   logic       perr_n, mreq, mfat;

   int errors = 0, checks = 0;
   logic [9:0] e_stat = '0;
   int         e_pend = 0;
   logic       e_perr_n = 1'b1, e_req = 1'b0, e_fat = 1'b0;

   always #4 clk = ~clk;

   bridge_uerr_report u_dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .perr_resp_en_i(pe),
      .serr_en_i(se), .fatal_rep_en_i(fe), .nonfatal_rep_en_i(ne),
      .sev_fatal_i(sev), .clr_we_i(cw), .clr_data_i(cd), .stat_o(stat),
      .perr_n_o(perr_n), .msg_req_o(mreq), .msg_fatal_o(mfat));

   function automatic logic [9:0] exp_set(logic [5:0] ev, logic p, logic [5:0] sv,
                                          logic f, logic n, logic s);
      logic [9:0] r = '0;
      logic fh = |(ev & 6'b110011 & sv);
      logic nh = |(ev & 6'b110011 & ~sv);
      r[0] = ev[0];
      r[7] = ev[0] | ev[4] | ev[5];
      r[4] = ev[4] | ev[5];
      r[8] = ev[1] | ev[2];
      r[6] = ev[3];
      r[9] = ev[3];
      r[5] = p & (ev[0] | ev[1] | ev[2] | ev[5]);
      r[1] = fh;
      r[2] = nh;
      r[3] = s & ((fh & f) | (nh & n));
      return r;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk(tag, "stat", int'(stat), int'(e_stat));
      chk(tag, "perr_n", int'(perr_n), int'(e_perr_n));
      chk(tag, "msg_req", int'(mreq), int'(e_req));
      chk(tag, "msg_fatal", int'(mfat), int'(e_fat));
   endtask

   // apply one cycle of stimulus at a negedge, check at the next negedge
   task automatic go(logic [5:0] ev, logic w, logic [9:0] d, string tag);
      logic fh, nh;
      int   tot;
      evt = ev; cw = w; cd = d;
      fh = |(ev & 6'b110011 & sev);
      nh = |(ev & 6'b110011 & ~sev);
      e_stat = exp_set(ev, pe, sev, fe, ne, se) | (e_stat & ~(w ? d : 10'h0));
      e_req  = (fh & fe) | (nh & ne);
      e_fat  = fh & fe;
      tot    = e_pend + (pe ? (int'(ev[0]) + int'(ev[5])) : 0);
      e_perr_n = (tot == 0);
      tot    = (tot == 0) ? 0 : tot - 1;
      e_pend = (tot > 7) ? 7 : tot;
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic clear_all();
      go(6'h0, 1'b1, 10'h3ff, "R11");
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R13");
      pe = 1; se = 1; fe = 1; ne = 1; sev = 6'b000000;
      go(6'b000001, 0, '0, "R1");  clear_all();
      go(6'b000010, 0, '0, "R2");  clear_all();
      go(6'b000100, 0, '0, "R3");  clear_all();
      go(6'b001000, 0, '0, "R4");  clear_all();
      go(6'b010000, 0, '0, "R5");  clear_all();
      go(6'b100000, 0, '0, "R6");  clear_all();
      pe = 0;
      go(6'b100011, 0, '0, "R7");  go(6'h0, 0, '0, "R7"); clear_all();
      pe = 1; sev = 6'b111111;
      go(6'b010000, 0, '0, "R8");  clear_all();
      fe = 0;
      go(6'b000001, 0, '0, "R9");  clear_all();
      fe = 1; sev = 6'b000001;
      go(6'b000011, 0, '0, "R9");  clear_all();
      se = 0;
      go(6'b010010, 0, '0, "R10"); clear_all();
      se = 1;
      go(6'b001001, 0, '0, "R11");
      go(6'h0, 1, 10'h000, "R11");
      go(6'h0, 1, 10'h201, "R11");
      go(6'b001000, 1, 10'h240, "R11");
      clear_all();
      go(6'b100001, 0, '0, "R12");
      go(6'h0, 0, '0, "R12");
      go(6'h0, 0, '0, "R12");
      repeat (6) go(6'b100001, 0, '0, "R12");
      repeat (10) go(6'h0, 0, '0, "R12");
      for (int k = 0; k < 3000; k++) begin
         logic [5:0] ev;
         if ($urandom % 16 == 0) begin
            pe = 1'($urandom); se = 1'($urandom);
            fe = 1'($urandom); ne = 1'($urandom); sev = 6'($urandom);
         end
         for (int b = 0; b < 6; b++) ev[b] = ($urandom % 5 == 0);
         go(ev, ($urandom % 4 == 0), 10'($urandom), "R1 R6 R9 R11 R12 random");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule